// File: doc/BRIEF.md
# I/O-Window Target for a Four-Bit Host Bus

This block is a peripheral-side responder for the low-pin-count host bus of a PC platform. It watches the framing strobe and the shared four-bit address/data lines. It claims only host I/O read and I/O write cycles whose 16-bit address falls inside a parameterised, power-of-two aligned window. Memory, firmware, DMA and bus-master cycles pass without reaction, and the target never enables its drivers for them.

Once a claimed cycle's header and the host turnaround are over, the target takes the lines. It reports wait status until its register back end is ready, signals completion, returns read data when the cycle is a read, and then hands the lines back through a two-clock turnaround. The back end sees a 16-bit address, a write byte, single-clock read or write strobes, a read byte input and a ready input. When ready is held low, the target holds the host in short-wait.

Top module: `lpc_io_target`

## Requirements
- R1: A cycle is claimed only when the last nibble seen while `frame_n` was low is 0000 and the next nibble (with `frame_n` high) has bits [3:2] = 00, bit 1 giving the direction (1 = write, bit 0 ignored). Any other start nibble or cycle-type nibble leaves `ad_oe` low and raises no strobe.
- R2: The four nibbles after the cycle type form the address, most significant nibble first, and are presented on `reg_addr` when a strobe is raised.
- R3: For writes, the two nibbles after the address form the write byte, low nibble first, and are presented on `reg_wdata` with the write strobe.
- R4: `ad_oe` stays low through the header, the write data and the two host turnaround clocks. The target first drives on the clock after the second turnaround clock.
- R5: In the status phase the target drives 0101 on each clock with `reg_ready` low and 0000 on the clock with `reg_ready` high, which ends the phase.
- R6: For reads, `reg_rd` is high during the 0000 status clock, `reg_rdata` is captured at the end of that clock, and the byte is driven low nibble then high nibble on the next two clocks.
- R7: The closing turnaround drives 1111 with `ad_oe` high for one clock, then `ad_oe` is low on the following clock.
- R8: A cycle whose address lies outside the window (`addr[15:WIN_LOG2]` differs from `WIN_BASE[15:WIN_LOG2]`) never raises `ad_oe` and raises no strobe.
- R9: A clock with `frame_n` low aborts any cycle in progress: no strobe is raised in that clock and `ad_oe` is low from the next clock.
- R10: The write strobe `reg_wr` is high for exactly one clock per completed write, during the 0000 status clock, and never together with `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low cycle framing strobe from the host |
| ad_i | input | 4 | Sampled value of the shared address/data lines |
| ad_o | output | 4 | Value the target drives onto the lines |
| ad_oe | output | 1 | Driver enable for the lines |
| reg_addr | output | 16 | Captured I/O address |
| reg_wdata | output | 8 | Captured write byte |
| reg_wr | output | 1 | Write strobe, one clock |
| reg_rd | output | 1 | Read strobe, one clock |
| reg_rdata | input | 8 | Read byte from the back end |
| reg_ready | input | 1 | Back end ready, ends wait states |

## Verification
Two events can land in the same clock: the back end raising ready during a status clock, and the host pulling `frame_n` low to abort. The bench provokes this by dropping `frame_n` with `reg_ready` high inside a wait sequence, on both reads and writes. It then requires that the target shows the completion code in that clock, with both strobes low, and that the lines are released on the next clock. Randomised cycles also abort at random wait positions, so the collision happens after different wait counts.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_ADDR,
        PH_WDAT,
        PH_TAR1,
        PH_SYNC,
        PH_RDAT,
        PH_TAR2
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [1:0] cnt;
        logic       wr;
    } seq_t;

    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned NIB_W     = 4;
    localparam int unsigned ADDR_NIBS = ADDR_W / NIB_W;
    localparam logic [1:0]  ADDR_LAST = 2'(ADDR_NIBS - 1);

    localparam logic [3:0] NIB_START_TGT = 4'h0;
    localparam logic [3:0] NIB_SYNC_WAIT = 4'h5;
    localparam logic [3:0] NIB_SYNC_OK   = 4'h0;
    localparam logic [3:0] NIB_TURN      = 4'hF;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int unsigned       lg);
        return (a >> lg) == (base >> lg);
    endfunction

endpackage

// File: rtl/lpc_io_seq.sv
module lpc_io_seq
    import lpc_io_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_n,
    input  logic [3:0] ad_i,
    input  logic       hit,
    input  logic       ready,
    output seq_t       seq
);
    logic start_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq      <= '{ph: PH_IDLE, cnt: 2'd0, wr: 1'b0};
            start_ok <= 1'b0;
        end else if (!frame_n) begin
            // Framing low: abort anything, last start nibble wins
            seq.ph   <= PH_START;
            seq.cnt  <= 2'd0;
            start_ok <= (ad_i == NIB_START_TGT);
        end else begin
            case (seq.ph)
                PH_START: begin
                    if (start_ok && ad_i[3:2] == 2'b00) begin
                        seq.ph  <= PH_ADDR;
                        seq.wr  <= ad_i[1];
                        seq.cnt <= 2'd0;
                    end else begin
                        seq.ph <= PH_IDLE;
                    end
                end
                PH_ADDR: begin
                    if (seq.cnt == ADDR_LAST) begin
                        seq.ph  <= seq.wr ? PH_WDAT : PH_TAR1;
                        seq.cnt <= 2'd0;
                    end else begin
                        seq.cnt <= seq.cnt + 2'd1;
                    end
                end
                PH_WDAT: begin
                    if (seq.cnt[0]) begin
                        seq.ph  <= PH_TAR1;
                        seq.cnt <= 2'd0;
                    end else begin
                        seq.cnt <= seq.cnt + 2'd1;
                    end
                end
                PH_TAR1: begin
                    if (seq.cnt[0]) begin
                        seq.ph  <= hit ? PH_SYNC : PH_IDLE;
                        seq.cnt <= 2'd0;
                    end else begin
                        seq.cnt <= seq.cnt + 2'd1;
                    end
                end
                PH_SYNC: begin
                    if (ready) begin
                        seq.ph  <= seq.wr ? PH_TAR2 : PH_RDAT;
                        seq.cnt <= 2'd0;
                    end
                end
                PH_RDAT: begin
                    if (seq.cnt[0]) begin
                        seq.ph  <= PH_TAR2;
                        seq.cnt <= 2'd0;
                    end else begin
                        seq.cnt <= seq.cnt + 2'd1;
                    end
                end
                PH_TAR2: begin
                    if (seq.cnt[0]) begin
                        seq.ph  <= PH_IDLE;
                        seq.cnt <= 2'd0;
                    end else begin
                        seq.cnt <= seq.cnt + 2'd1;
                    end
                end
                default: begin
                    seq.ph  <= PH_IDLE;
                    seq.cnt <= 2'd0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lpc_io_capture.sv
module lpc_io_capture
    import lpc_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  seq_t              seq,
    input  logic [3:0]        ad_i,
    input  logic              ready,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wdata,
    output logic [7:0]        rbuf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            wdata <= '0;
            rbuf  <= '0;
        end else if (frame_n) begin
            case (seq.ph)
                PH_ADDR: addr <= {addr[ADDR_W-NIB_W-1:0], ad_i};
                PH_WDAT: begin
                    if (seq.cnt[0]) wdata[7:4] <= ad_i;
                    else            wdata[3:0] <= ad_i;
                end
                PH_SYNC: if (ready && !seq.wr) rbuf <= rdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lpc_io_drive.sv
module lpc_io_drive
    import lpc_io_pkg::*;
(
    input  seq_t       seq,
    input  logic       ready,
    input  logic [7:0] rbuf,
    output logic [3:0] ad_o,
    output logic       ad_oe
);
    always_comb begin
        ad_oe = 1'b0;
        ad_o  = NIB_TURN;
        case (seq.ph)
            PH_SYNC: begin
                ad_oe = 1'b1;
                ad_o  = ready ? NIB_SYNC_OK : NIB_SYNC_WAIT;
            end
            PH_RDAT: begin
                ad_oe = 1'b1;
                ad_o  = seq.cnt[0] ? rbuf[7:4] : rbuf[3:0];
            end
            PH_TAR2: begin
                ad_oe = (seq.cnt == 2'd0);
                ad_o  = NIB_TURN;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
    import lpc_io_pkg::*;
#(
    parameter logic [15:0] WIN_BASE = 16'h02E0,
    parameter int unsigned WIN_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic [3:0]  ad_i,
    output logic [3:0]  ad_o,
    output logic        ad_oe,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        reg_wr,
    output logic        reg_rd,
    input  logic [7:0]  reg_rdata,
    input  logic        reg_ready
);
    seq_t        seq;
    logic [15:0] addr_q;
    logic [7:0]  rbuf;
    logic        addr_hit;
    logic        done_now;

    assign addr_hit = in_window(addr_q, WIN_BASE, WIN_LOG2);

    lpc_io_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .ad_i    (ad_i),
        .hit     (addr_hit),
        .ready   (reg_ready),
        .seq     (seq)
    );

    lpc_io_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .seq     (seq),
        .ad_i    (ad_i),
        .ready   (reg_ready),
        .rdata   (reg_rdata),
        .addr    (addr_q),
        .wdata   (reg_wdata),
        .rbuf    (rbuf)
    );

    lpc_io_drive u_drv (
        .seq   (seq),
        .ready (reg_ready),
        .rbuf  (rbuf),
        .ad_o  (ad_o),
        .ad_oe (ad_oe)
    );

    // Completion clock; an abort in the same clock suppresses the strobe
    assign done_now  = (seq.ph == PH_SYNC) && reg_ready && frame_n;
    assign reg_wr    = done_now && seq.wr;
    assign reg_rd    = done_now && !seq.wr;
    assign reg_addr  = addr_q;
endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_n,
    input logic [3:0] ad_o,
    input logic       ad_oe,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_ready,
    input logic       addr_hit
);
    p_single_wr_r10: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    p_excl_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    p_strobe_on_ok_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd) |-> (ad_oe && ad_o == 4'h0 && reg_ready && frame_n));

    p_abort_release_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> !ad_oe);

    p_window_only_r8: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> addr_hit);

    p_first_drive_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ad_oe) |-> (ad_o == 4'h5 || ad_o == 4'h0));
endmodule

bind lpc_io_target lpc_io_target_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_ready (reg_ready),
    .addr_hit  (addr_hit)
);

// File: tb/tb_lpc_io_target.sv
module tb_lpc_io_target;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h02E0;
    localparam int LG = 3;

    logic clk = 1'b0;
    logic rst;
    logic frame_n;
    logic [3:0] ad_i;
    logic [3:0] ad_o;
    logic ad_oe;
    logic [15:0] reg_addr;
    logic [7:0] reg_wdata;
    logic reg_wr;
    logic reg_rd;
    logic [7:0] reg_rdata;
    logic reg_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpc_io_target #(.WIN_BASE(BASE), .WIN_LOG2(LG)) dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ad_i(ad_i),
        .ad_o(ad_o), .ad_oe(ad_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .reg_ready(reg_ready)
    );

    function automatic bit exp_hit(input logic [15:0] a);
        return a[15:LG] == BASE[15:LG];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_quiet(input string req);
        check(ad_oe == 1'b0, req, "ad_oe", int'(ad_oe), 0);
        check(reg_wr == 1'b0 && reg_rd == 1'b0, req, "strobes",
              int'({reg_wr, reg_rd}), 0);
    endtask

    task automatic expect_drive(input string req, input logic [3:0] v);
        check(ad_oe == 1'b1, req, "ad_oe", int'(ad_oe), 1);
        check(ad_o == v, req, "ad_o", int'(ad_o), int'(v));
    endtask

    // One bus clock: inputs set after the falling edge, outputs read 1 later
    task automatic step(input logic f, input logic [3:0] a, input logic rdy);
        @(negedge clk);
        frame_n   = f;
        ad_i      = a;
        reg_ready = rdy;
        #1;
    endtask

    task automatic io_cycle(input bit wr, input logic [15:0] a,
                            input logic [7:0] d, input int waits,
                            input int abort_at);
        bit hit;
        hit = exp_hit(a);
        step(1'b0, 4'h0, 1'b0);
        expect_quiet("R1");
        step(1'b1, {2'b00, wr, 1'b0}, 1'b0);
        expect_quiet("R4");
        for (int i = 0; i < 4; i++) begin
            step(1'b1, a[15-4*i -: 4], 1'b0);
            expect_quiet("R4");
        end
        if (wr) begin
            step(1'b1, d[3:0], 1'b0);
            expect_quiet("R4");
            step(1'b1, d[7:4], 1'b0);
            expect_quiet("R4");
        end
        step(1'b1, 4'hF, 1'b0);
        expect_quiet("R4");
        step(1'b1, 4'hF, 1'b0);
        expect_quiet("R4");
        if (!hit) begin
            for (int i = 0; i < 4; i++) begin
                step(1'b1, 4'hF, 1'b1);
                expect_quiet("R8");
            end
            return;
        end
        for (int w = 0; w < waits; w++) begin
            if (w == abort_at) begin
                // Ready and abort in the same clock
                step(1'b0, 4'hF, 1'b1);
                expect_drive("R9", 4'h0);
                check(reg_wr == 1'b0 && reg_rd == 1'b0, "R9", "strobe on abort",
                      int'({reg_wr, reg_rd}), 0);
                step(1'b1, 4'hF, 1'b0);
                expect_quiet("R9");
                step(1'b1, 4'hF, 1'b0);
                expect_quiet("R9");
                return;
            end
            step(1'b1, 4'hF, 1'b0);
            expect_drive("R5", 4'h5);
            check(reg_wr == 1'b0 && reg_rd == 1'b0, "R10", "early strobe",
                  int'({reg_wr, reg_rd}), 0);
        end
        reg_rdata = d;
        step(1'b1, 4'hF, 1'b1);
        expect_drive("R5", 4'h0);
        check(reg_addr == a, "R2", "reg_addr", int'(reg_addr), int'(a));
        if (wr) begin
            check(reg_wr == 1'b1 && reg_rd == 1'b0, "R10", "wr strobe",
                  int'({reg_wr, reg_rd}), 2);
            check(reg_wdata == d, "R3", "reg_wdata", int'(reg_wdata), int'(d));
        end else begin
            check(reg_rd == 1'b1 && reg_wr == 1'b0, "R6", "rd strobe",
                  int'({reg_wr, reg_rd}), 1);
            @(posedge clk);
            #1;
            reg_rdata = ~d;
            step(1'b1, 4'hF, 1'b0);
            expect_drive("R6", d[3:0]);
            step(1'b1, 4'hF, 1'b0);
            expect_drive("R6", d[7:4]);
        end
        step(1'b1, 4'hF, 1'b1);
        expect_drive("R7", 4'hF);
        check(reg_wr == 1'b0, "R10", "second wr strobe", int'(reg_wr), 0);
        step(1'b1, 4'hF, 1'b1);
        expect_quiet("R7");
        step(1'b1, 4'hF, 1'b0);
        expect_quiet("R7");
    endtask

    task automatic ignored(input logic [3:0] st, input logic [3:0] ct);
        step(1'b0, st, 1'b0);
        step(1'b1, ct, 1'b0);
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 4'hF, 1'b1);
            expect_quiet("R1");
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        bit          wr;
        int          waits;
        int          ab;
        void'($urandom(32'h1234_5678));
        rst = 1'b1; frame_n = 1'b1; ad_i = 4'hF; reg_ready = 1'b0; reg_rdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        expect_quiet("R1");
        step(1'b1, 4'hF, 1'b0);

        // Directed cycles
        io_cycle(1'b1, 16'h02E3, 8'hA5, 0, -1);
        io_cycle(1'b0, 16'h02E7, 8'h3C, 2, -1);
        io_cycle(1'b1, 16'h02E0, 8'h0F, 3, -1);
        io_cycle(1'b0, 16'h02E1, 8'hF0, 0, -1);
        io_cycle(1'b1, 16'h02E8, 8'h11, 1, -1);   // just above window
        io_cycle(1'b0, 16'h02DF, 8'h22, 1, -1);   // just below window
        io_cycle(1'b1, 16'h02E2, 8'h77, 3, 1);    // write aborted with ready
        io_cycle(1'b0, 16'h02E4, 8'h88, 2, 0);    // read aborted with ready
        ignored(4'h0, 4'h4);                       // memory read
        ignored(4'h0, 4'h6);                       // memory write
        ignored(4'h0, 4'h8);                       // DMA
        ignored(4'hD, 4'h0);                       // firmware start code
        step(1'b0, 4'h0, 1'b0);
        ignored(4'hF, 4'h0);                       // last start nibble is not 0000
        step(1'b0, 4'h5, 1'b0);
        io_cycle(1'b0, 16'h02E6, 8'h5A, 1, -1);   // last start nibble is 0000

        // Randomised cycles
        for (int k = 0; k < 80; k++) begin
            wr = 1'($urandom % 2);
            a = 16'($urandom);
            if ($urandom % 2 == 0) a = {BASE[15:LG], a[LG-1:0]};
            d = 8'($urandom);
            waits = int'($urandom % 4);
            ab = -1;
            if (waits > 0 && $urandom % 6 == 0) ab = int'($urandom % waits);
            io_cycle(wr, a, d, waits, ab);
            step(1'b1, 4'hF, 1'b0);
        end

        finished = 1'b1;
        summary();
    end
endmodule